// File: doc/BRIEF.md
# Two-Level Rotating-Priority Interrupt Controller

This block gathers up to 32 interrupt request lines and produces two processor interrupt outputs, a fast one and a normal one. Every source has a pending bit, a mode bit that routes it to the fast output, and a mask bit. A source in fast mode with its pending bit set raises the fast output at once and skips arbitration. Normal sources that are pending and unmasked compete in two stages. Six group arbiters each cover up to six sources, and one top arbiter chooses among the six group winners.

The winning source number is stored in a read-only offset register. The winner's bit is also set in an in-service register. Software acknowledges an interrupt by writing ones to the source-pending and in-service registers. While any in-service bit is set, no new winner is chosen.

Each arbiter has a 2-bit selector and a rotate enable. Both live in a packed priority register, and a read of that register shows the selectors as they stand after any automatic rotation.

Top module: `intc_vec_top`

## Requirements
- R1: After reset the mask register reads 0xFFFFFFFF, the priority register reads 0x0000007F, the source-pending, mode, in-service and offset registers read 0, and both interrupt outputs are low. Word offsets: 0x00 source-pending, 0x04 mode, 0x08 mask, 0x0C priority, 0x10 in-service, 0x14 offset.
- R2: A request line going from low to high sets that source's pending bit on the same clock edge. A pulsed request stays recorded after the line falls.
- R3: Writing to source-pending clears each bit written as 1. If the request line of that source is still high, its bit stays set.
- R4: Every write to the mode register forces bits 6 and 24 to 0, and every write to the mask register forces them to 1.
- R5: The fast output is high one edge after any source is both pending and in fast mode. While that holds, no IRQ winner is latched.
- R6: If the in-service register is zero, there is no fast request, and pending AND NOT mask is nonzero, then the next edge writes the winner's number into the offset register, sets only that bit in the in-service register, and raises the IRQ output.
- R7: While the in-service register is nonzero, the offset register does not change and no new winner is latched, even when a higher-priority source becomes pending. Writes to the offset register are ignored. Writing 1s to the in-service register clears those bits.
- R8: Source s belongs to group s/6, slot s%6. A group arbiter with selector v checks slot 0 first and slot 5 last. It checks the middle slots in the order 1+v, then upward, wrapping within 1..4.
- R9: The top arbiter applies the same order to group numbers, using its own selector.
- R10: The priority register has 21 bits. Bit i is the rotate enable of arbiter i (arbiters 0..5 are the groups, 6 is the top). Bits [8+2i:7+2i] hold selector i, and bits above 20 read 0. When a winner is latched, every arbiter that has its rotate enable set and holds a request advances its selector by one, modulo 4.
- R11: The IRQ output is low whenever the in-service register is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 32 | Synchronous request lines, one per source |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Byte address; only word-aligned addresses decode |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| fiq_o | output | 1 | Fast interrupt request, registered |
| irq_o | output | 1 | Normal interrupt request, registered |

## Verification
The assertions assume that software only clears the in-service register and never sets bits in it. They also assume that winners are latched only from state already held in registers, so a write and an arbitration on the same edge never disagree about the in-service bits. The bench meets this by driving register writes and request pulses on falling edges, one operation at a time. Before it raises new requests, it waits until earlier winners are acknowledged by clearing both source-pending and in-service. The two reserved source positions stay masked throughout, so no sweep expects them to win.

// File: rtl/intc_vec_pkg.sv
package intc_vec_pkg;
   localparam int SLOTS = 6;
   localparam int SEL_W = 2;
   localparam int IDX_W = 3;

   // register word indices (byte offset >> 2)
   localparam logic [2:0] RG_SRC  = 3'd0;
   localparam logic [2:0] RG_MODE = 3'd1;
   localparam logic [2:0] RG_MASK = 3'd2;
   localparam logic [2:0] RG_PRIO = 3'd3;
   localparam logic [2:0] RG_SVC  = 3'd4;
   localparam logic [2:0] RG_OFF  = 3'd5;

   // slot checked at position pos for selector sel: slot 0 first, slot 5 last,
   // middle four rotate with the selector
   function automatic logic [IDX_W-1:0] slot_at(input logic [SEL_W-1:0] sel, input int pos);
      if (pos == 0) return '0;
      if (pos == SLOTS - 1) return IDX_W'(SLOTS - 1);
      return IDX_W'(1 + ((pos - 1 + int'(sel)) % 4));
   endfunction
endpackage

// File: rtl/intc_rot_arb.sv
module intc_rot_arb
   import intc_vec_pkg::*;
#(
   parameter int N = SLOTS
) (
   input  logic [N-1:0]     req_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             hit_o,
   output logic [IDX_W-1:0] idx_o
);
   if (N != SLOTS) begin : g_bad_width
      $error("intc_rot_arb: N must equal SLOTS");
   end

   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      // walk from lowest priority to highest so the first in order wins
      for (int p = N - 1; p >= 0; p--) begin
         if (req_i[slot_at(sel_i, p)]) begin
            hit_o = 1'b1;
            idx_o = slot_at(sel_i, p);
         end
      end
   end
endmodule

// File: rtl/intc_src_pend.sv
module intc_src_pend #(
   parameter int N = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o,
   output logic [N-1:0] pend_nxt_o
);
   logic [N-1:0] held_q;
   logic [N-1:0] pend_q;

   // clear written ones, but keep sources whose line is still held high
   assign pend_nxt_o = (pend_q & ~clr_i) | (clr_i & held_q) | (req_i & ~held_q);
   assign pend_o     = pend_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         held_q <= '0;
         pend_q <= '0;
      end else begin
         held_q <= req_i;
         pend_q <= pend_nxt_o;
      end
   end
endmodule

// File: rtl/intc_vec_top.sv
module intc_vec_top
   import intc_vec_pkg::*;
#(
   parameter int          NUM_SRC = 32,
   parameter int          NUM_GRP = 6,
   parameter int          AW      = 5,
   parameter logic [31:0] RSVD    = 32'h0100_0040
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [31:0]   req_i,
   input  logic          we_i,
   input  logic [AW-1:0] addr_i,
   input  logic [31:0]   wdata_i,
   output logic [31:0]   rdata_o,
   output logic          fiq_o,
   output logic          irq_o
);
   localparam int DW     = 32;
   localparam int NARB   = NUM_GRP + 1;
   localparam int PRIO_W = NARB * (1 + SEL_W);
   localparam int OFF_W  = $clog2(NUM_SRC);
   localparam logic [NUM_SRC-1:0] RSV = RSVD[NUM_SRC-1:0];

   if (NUM_SRC != DW || NUM_SRC > NUM_GRP * SLOTS || NUM_GRP > SLOTS || AW < 5 || PRIO_W > DW)
   begin : g_bad_cfg
      $error("intc_vec_top: unsupported configuration");
   end

   logic [2:0] reg_sel;
   logic       reg_ok;
   assign reg_sel = addr_i[4:2];
   assign reg_ok  = (addr_i[1:0] == 2'b00) && (addr_i[AW-1:2] == (AW-2)'(reg_sel));

   logic wr_src, wr_mode, wr_mask, wr_prio, wr_svc;
   assign wr_src  = we_i && reg_ok && reg_sel == RG_SRC;
   assign wr_mode = we_i && reg_ok && reg_sel == RG_MODE;
   assign wr_mask = we_i && reg_ok && reg_sel == RG_MASK;
   assign wr_prio = we_i && reg_ok && reg_sel == RG_PRIO;
   assign wr_svc  = we_i && reg_ok && reg_sel == RG_SVC;

   logic [NUM_SRC-1:0] src_pnd, src_pnd_n;
   logic [NUM_SRC-1:0] mode_q, mode_n, mask_q, int_pnd_q, int_pnd_n;
   logic [OFF_W-1:0]   off_q;
   logic [NARB-1:0]    rot_q;
   logic [SEL_W-1:0]   sel_q [NARB];

   intc_src_pend #(.N(NUM_SRC)) u_pend (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .req_i      (req_i),
      .clr_i      (wr_src ? wdata_i : '0),
      .pend_o     (src_pnd),
      .pend_nxt_o (src_pnd_n)
   );

   // first level: one rotating arbiter per group
   logic [NUM_SRC-1:0] svc_vec;
   assign svc_vec = src_pnd & ~mask_q;

   logic [SLOTS-1:0] grp_req [NUM_GRP];
   logic [NUM_GRP-1:0] grp_hit;
   logic [IDX_W-1:0] grp_idx [NUM_GRP];

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      for (genvar k = 0; k < SLOTS; k++) begin : g_slot
         if (g * SLOTS + k < NUM_SRC) begin : g_used
            assign grp_req[g][k] = svc_vec[g*SLOTS+k];
         end else begin : g_empty
            assign grp_req[g][k] = 1'b0;
         end
      end
      intc_rot_arb #(.N(SLOTS)) u_arb (
         .req_i (grp_req[g]),
         .sel_i (sel_q[g]),
         .hit_o (grp_hit[g]),
         .idx_o (grp_idx[g])
      );
   end

   // second level over the group winners
   logic [SLOTS-1:0] top_req;
   logic             top_hit;
   logic [IDX_W-1:0] top_idx;
   assign top_req = SLOTS'(grp_hit);

   intc_rot_arb #(.N(SLOTS)) u_top (
      .req_i (top_req),
      .sel_i (sel_q[NUM_GRP]),
      .hit_o (top_hit),
      .idx_o (top_idx)
   );

   logic [OFF_W-1:0] win_src;
   always_comb begin
      win_src = '0;
      for (int g = 0; g < NUM_GRP; g++) begin
         if (top_idx == IDX_W'(g)) win_src = OFF_W'(g * SLOTS) + OFF_W'(grp_idx[g]);
      end
   end

   logic fiq_now, go;
   assign fiq_now = |(src_pnd & mode_q);
   assign go      = !fiq_now && (int_pnd_q == '0) && top_hit;

   assign mode_n    = wr_mode ? (wdata_i & ~RSV) : mode_q;
   assign int_pnd_n = (int_pnd_q & ~(wr_svc ? wdata_i : '0))
                    | (go ? (NUM_SRC'(1) << win_src) : '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q    <= '0;
         mask_q    <= '1;
         int_pnd_q <= '0;
         off_q     <= '0;
         rot_q     <= '1;
         for (int i = 0; i < NARB; i++) sel_q[i] <= '0;
         fiq_o     <= 1'b0;
         irq_o     <= 1'b0;
      end else begin
         mode_q    <= mode_n;
         int_pnd_q <= int_pnd_n;
         if (wr_mask) mask_q <= wdata_i | RSV;
         if (go) off_q <= win_src;
         if (wr_prio) begin
            rot_q <= wdata_i[NARB-1:0];
            for (int i = 0; i < NARB; i++) sel_q[i] <= wdata_i[NARB+SEL_W*i +: SEL_W];
         end else if (go) begin
            for (int i = 0; i < NUM_GRP; i++) begin
               if (grp_hit[i] && rot_q[i]) sel_q[i] <= sel_q[i] + 1'b1;
            end
            if (rot_q[NUM_GRP]) sel_q[NUM_GRP] <= sel_q[NUM_GRP] + 1'b1;
         end
         fiq_o <= |(src_pnd_n & mode_n);
         irq_o <= |int_pnd_n;
      end
   end

   logic [PRIO_W-1:0] prio_rd;
   always_comb begin
      prio_rd = '0;
      for (int i = 0; i < NARB; i++) begin
         prio_rd[i] = rot_q[i];
         prio_rd[NARB+SEL_W*i +: SEL_W] = sel_q[i];
      end
   end

   always_comb begin
      rdata_o = '0;
      if (reg_ok) begin
         case (reg_sel)
            RG_SRC:  rdata_o = DW'(src_pnd);
            RG_MODE: rdata_o = DW'(mode_q);
            RG_MASK: rdata_o = DW'(mask_q);
            RG_PRIO: rdata_o = DW'(prio_rd);
            RG_SVC:  rdata_o = DW'(int_pnd_q);
            RG_OFF:  rdata_o = DW'(off_q);
            default: rdata_o = '0;
         endcase
      end
   end
endmodule

// File: rtl/intc_vec_chk.sv
module intc_vec_chk #(
   parameter int          NUM_SRC = 32,
   parameter int          OFF_W   = 5,
   parameter logic [31:0] RSVD    = 32'h0100_0040
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic [NUM_SRC-1:0] src_pnd,
   input logic [NUM_SRC-1:0] mode,
   input logic [NUM_SRC-1:0] mask,
   input logic [NUM_SRC-1:0] int_pnd,
   input logic [OFF_W-1:0]   off,
   input logic               irq
);
   localparam logic [NUM_SRC-1:0] RSV = RSVD[NUM_SRC-1:0];

   // R4
   mask_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask & RSV) == RSV);

   // R4
   mode_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode & RSV) == '0);

   // R5
   fiq_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((|(src_pnd & mode)) && int_pnd == '0) |=> int_pnd == '0);

   // R6
   svc_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(int_pnd));

   // R6
   latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!(|(src_pnd & mode)) && int_pnd == '0 && (|(src_pnd & ~mask)))
      |=> (irq && int_pnd[off]));

   // R7
   off_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (int_pnd != '0) |=> $stable(off));
endmodule

bind intc_vec_top intc_vec_chk #(
   .NUM_SRC (NUM_SRC),
   .OFF_W   (OFF_W),
   .RSVD    (RSVD)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .src_pnd (src_pnd),
   .mode    (mode_q),
   .mask    (mask_q),
   .int_pnd (int_pnd_q),
   .off     (off_q),
   .irq     (irq_o)
);

// File: tb/intc_vec_top_tb.sv
module intc_vec_top_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] req;
   logic        we;
   logic [4:0]  addr;
   logic [31:0] wdata;
   logic [31:0] rdata;
   logic        fiq, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [4:0] A_SRC = 5'h00, A_MODE = 5'h04, A_MASK = 5'h08,
                          A_PRIO = 5'h0C, A_SVC = 5'h10, A_OFF = 5'h14;

   always #5 clk = ~clk;

   intc_vec_top u_dut (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
      .wdata_i(wdata), .rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(tag, v, exp);
   endtask

   task automatic pulse(input logic [31:0] m);
      @(negedge clk); req = m;
      @(negedge clk); req = '0;
   endtask

   task automatic ack(input logic [31:0] m);
      wr(A_SRC, m);
      wr(A_SVC, 32'hFFFF_FFFF);
   endtask

   // expected first-in-order slot for a 6-bit request set and selector
   function automatic int exp_slot(input int sel, input logic [5:0] bits);
      for (int p = 0; p < 6; p++) begin
         int s;
         s = (p == 0) ? 0 : (p == 5) ? 5 : 1 + ((p - 1 + sel) % 4);
         if (bits[s]) return s;
      end
      return -1;
   endfunction

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; req = '0; we = 1'b0; addr = '0; wdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rdchk("R1 src", A_SRC, 32'h0);
      rdchk("R1 mode", A_MODE, 32'h0);
      rdchk("R1 mask", A_MASK, 32'hFFFF_FFFF);
      rdchk("R1 prio", A_PRIO, 32'h7F);
      rdchk("R1 svc", A_SVC, 32'h0);
      rdchk("R1 off", A_OFF, 32'h0);
      chk("R1 fiq", {31'b0, fiq}, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);

      // R4 reserved positions
      wr(A_MODE, 32'hFFFF_FFFF);
      rdchk("R4 mode", A_MODE, 32'hFEFF_FFBF);
      wr(A_MODE, 32'h0);
      wr(A_MASK, 32'h0);
      rdchk("R4 mask", A_MASK, 32'h0100_0040);

      // R10 width of priority register
      wr(A_PRIO, 32'hFFFF_FFFF);
      rdchk("R10 prio width", A_PRIO, 32'h001F_FFFF);
      wr(A_PRIO, 32'h0);

      // R2 R6 R11 single-source sweep
      for (int s = 0; s < 32; s++) begin
         if (s == 6 || s == 24) continue;
         wr(A_MASK, ~(32'h1 << s));
         pulse(32'h1 << s);
         rdchk("R2 pending on rise", A_SRC, 32'h1 << s);
         chk("R6 no irq before latch", {31'b0, irq}, 32'h0);
         @(negedge clk);
         rdchk("R6 offset", A_OFF, 32'(s));
         rdchk("R6 in-service", A_SVC, 32'h1 << s);
         chk("R6 irq", {31'b0, irq}, 32'h1);
         ack(32'h1 << s);
         rdchk("R7 svc cleared", A_SVC, 32'h0);
         chk("R11 irq low", {31'b0, irq}, 32'h0);
      end

      // R8 first-level order, rotation off
      wr(A_MASK, ~32'h0000_003F);
      for (int sel = 0; sel < 4; sel++) begin
         for (int pat = 1; pat < 64; pat += 5) begin
            wr(A_PRIO, 32'(sel) << 7);
            pulse(32'(pat));
            @(negedge clk);
            rdchk("R8 group order", A_OFF, 32'(exp_slot(sel, 6'(pat))));
            ack(32'h3F);
         end
      end

      // R9 second-level order over groups 1..4
      wr(A_MASK, ~32'h0208_2080);
      for (int t = 0; t < 4; t++) begin
         wr(A_PRIO, 32'(t) << 19);
         pulse(32'h0208_2080);
         @(negedge clk);
         rdchk("R9 top order", A_OFF, 32'((1 + t) * 6 + 1));
         ack(32'h0208_2080);
      end

      // R10 rotation of group 0 only
      wr(A_MASK, ~32'h1E);
      wr(A_PRIO, 32'h01);
      pulse(32'h6);
      @(negedge clk);
      rdchk("R10 first winner", A_OFF, 32'd1);
      rdchk("R10 selector advanced", A_PRIO, 32'h81);
      ack(32'h6);
      pulse(32'h6);
      @(negedge clk);
      rdchk("R10 rotated winner", A_OFF, 32'd2);
      rdchk("R10 selector again", A_PRIO, 32'h101);
      ack(32'h6);

      // R7 in-service freezes arbitration
      wr(A_PRIO, 32'h0);
      wr(A_MASK, ~32'h3);
      pulse(32'h2);
      @(negedge clk);
      pulse(32'h1);
      @(negedge clk);
      rdchk("R7 offset held", A_OFF, 32'd1);
      rdchk("R7 svc held", A_SVC, 32'h2);
      chk("R7 irq held", {31'b0, irq}, 32'h1);
      wr(A_OFF, 32'h0);
      rdchk("R7 offset read-only", A_OFF, 32'd1);
      wr(A_SRC, 32'h2);
      wr(A_SVC, 32'h2);
      @(negedge clk);
      rdchk("R7 next winner", A_OFF, 32'd0);
      rdchk("R7 next svc", A_SVC, 32'h1);
      ack(32'h1);

      // R3 held request survives clear
      wr(A_MASK, 32'hFFFF_FFFF);
      @(negedge clk); req = 32'h8;
      repeat (2) @(negedge clk);
      rdchk("R3 held pending", A_SRC, 32'h8);
      wr(A_SRC, 32'h8);
      rdchk("R3 clear while held", A_SRC, 32'h8);
      req = '0;
      @(negedge clk);
      wr(A_SRC, 32'h8);
      rdchk("R3 clear after release", A_SRC, 32'h0);

      // R5 fast path bypasses arbitration
      wr(A_MODE, 32'h400);
      wr(A_MASK, ~32'h400);
      pulse(32'h400);
      chk("R5 fiq high", {31'b0, fiq}, 32'h1);
      repeat (2) @(negedge clk);
      rdchk("R5 no svc", A_SVC, 32'h0);
      chk("R5 no irq", {31'b0, irq}, 32'h0);
      wr(A_SRC, 32'h400);
      chk("R5 fiq low", {31'b0, fiq}, 32'h0);
      wr(A_MODE, 32'h0);
      rd(A_SVC, v);
      chk("R11 idle svc", v, 32'h0);

      done = 1'b1;
      finish_run();
   end
endmodule